// File: doc/BRIEF.md
# Forwarded-Packet Connectivity Record Writer

The block turns every packet that the switch forwards into a small connectivity record. Each record holds the destination port mask, the packet byte count, the destination MAC address and the source MAC address. The forwarding logic hands over one descriptor per packet in a single cycle. The block holds the descriptors in a short internal queue and writes each record into an external FIFO device.

The external FIFO sits on the data bus that the memory controller owns. The block raises a request for that bus and waits for a grant. While it drives a record word it also holds a dedicated active-low chip-select. It writes four 32-bit words in a fixed order. In multi-word mode the four words go out as one burst under a single grant. In single-word mode each word is a separate burst, and the block releases the bus between words.

The block never starts a burst while the external FIFO reports full. If a descriptor arrives while the queue is already full, the descriptor is dropped and a saturating overflow counter is incremented.

Top module: `conn_rec_writer`

## Requirements
- R1: Every accepted descriptor produces exactly one record of four words. Records leave in the order their descriptors arrived.
- R2: Word 0 is the port mask, zero-extended to 16 bits, in bits 31:16, and the byte count in bits 15:0. Word 1 is the destination address bits 47:16. Word 2 is the destination address bits 15:0 in bits 31:16, and the source address bits 47:32 in bits 15:0. Word 3 is the source address bits 31:0.
- R3: `fifo_cs_n` is low in exactly the cycles in which `bus_oe` is high. `bus_data` is zero whenever `bus_oe` is low.
- R4: A burst starts, meaning `fifo_cs_n` falls, only in the cycle after a clock edge at which `bus_gnt` was 1. `bus_req` is high through the whole burst.
- R5: With `single_mode` at 0 when the burst starts, all four words of a record go out in four consecutive cycles under one chip-select.
- R6: With `single_mode` at 1, each burst carries one word. After every burst, in either mode, `bus_req` is low for at least one cycle.
- R7: No burst starts in the cycle after a clock edge at which `fifo_full` was 1. While `fifo_full` stays 1, a pending record waits.
- R8: The queue holds 4 descriptors. A descriptor that arrives while 4 are held is dropped, and `ovf_cnt` increases by 1.
- R9: After reset, `fifo_cs_n` is 1, `bus_req` and `bus_oe` are 0, `bus_data` is 0 and `ovf_cnt` is 0.
- R10: `ovf_cnt` saturates at its maximum value, 255 by default, and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_valid | input | 1 | One-cycle descriptor strobe from forwarding logic |
| desc_ports | input | PORTS | Destination port mask |
| desc_bytes | input | 16 | Packet byte count |
| desc_da | input | 48 | Destination MAC address |
| desc_sa | input | 48 | Source MAC address |
| single_mode | input | 1 | 1 = one word per burst, 0 = four-word burst |
| fifo_full | input | 1 | External FIFO full flag |
| bus_gnt | input | 1 | Shared data bus grant |
| bus_req | output | 1 | Shared data bus request |
| bus_oe | output | 1 | Drive enable for the shared data lines |
| bus_data | output | 32 | Record word on the shared data lines |
| fifo_cs_n | output | 1 | Active-low chip-select of the external FIFO |
| ovf_cnt | output | OVF_W | Saturating count of dropped descriptors |

## Verification
The assertions assume that the arbiter raises `bus_gnt` only while `bus_req` is high and keeps it high until the request falls. They also assume that `single_mode` and `fifo_full` change only while no burst is in progress. The bench's arbiter model grants after a programmable delay, counted from the request, and withdraws the grant one cycle after the request drops. The tests change the mode and the full flag only after the record queue has drained, or before a record has been granted the bus. Overflow is provoked by holding the full flag, so the queue cannot drain while descriptors keep arriving.

// File: rtl/crw_pkg.sv
// Shared types for the connectivity record writer.
// Assumes a 32-bit shared data bus and a record of four words.
package crw_pkg;
    localparam int WORD_W      = 32;
    localparam int MAC_W       = 48;
    localparam int BYTES_W     = 16;
    localparam int MASK_FLD_W  = 16;
    localparam int REC_WORDS   = 4;
    localparam int IDX_W       = $clog2(REC_WORDS);

    typedef struct packed {
        logic [MASK_FLD_W-1:0] ports;
        logic [BYTES_W-1:0]    bytes;
        logic [MAC_W-1:0]      da;
        logic [MAC_W-1:0]      sa;
    } rec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } bus_st_e;
endpackage

// File: rtl/crw_queue.sv
// Descriptor queue: a circular buffer of DEPTH records with an overflow counter.
// Assumes pop is asserted only while the queue is not empty.
// A push that arrives while DEPTH entries are held is dropped, even when a pop
// happens in the same cycle. Each drop increments a saturating counter.
module crw_queue
    import crw_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int OVF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  rec_t             push_data,
    input  logic             pop,
    output rec_t             head,
    output logic             empty,
    output logic [OVF_W-1:0] ovf_cnt
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [OVF_W-1:0] OVF_MAX  = {OVF_W{1'b1}};

    rec_t             mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             full, accept;

    assign full   = (count == FULL_CNT);
    assign empty  = (count == '0);
    assign accept = push_valid && !full;
    assign head   = mem[rd_ptr];

    // Store an accepted descriptor at the write pointer.
    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= push_data;
    end

    // Advance the pointers and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop)    rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({accept, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Count descriptors dropped at a full queue, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  ovf_cnt <= '0;
        else if (push_valid && full && ovf_cnt != OVF_MAX) ovf_cnt <= ovf_cnt + 1'b1;
    end

    // R8: occupancy never exceeds the depth.
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R8: a drop at a full queue raises the counter by one.
    a_r8_ovf_step: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && full && ovf_cnt != OVF_MAX) |=> ovf_cnt == OVF_W'($past(ovf_cnt) + 1'b1));

    // R10: the counter stays at its maximum once it gets there.
    a_r10_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_cnt == OVF_MAX) |=> ovf_cnt == OVF_MAX);

    // R1: a record is never taken from an empty queue.
    a_r1_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/crw_formatter.sv
// Record formatter: selects one bus word of the head record.
// Assumes a 32-bit word. Word order is port mask with byte count, destination
// address high, destination address low with source address high, and source
// address low.
module crw_formatter
    import crw_pkg::*;
(
    input  rec_t              rec,
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] words [REC_WORDS];

    assign words[0] = {rec.ports, rec.bytes};
    assign words[1] = rec.da[47:16];
    assign words[2] = {rec.da[15:0], rec.sa[47:32]};
    assign words[3] = rec.sa[31:0];

    // Pick the word for the current beat.
    always_comb word = words[idx];
endmodule

// File: rtl/crw_bus_fsm.sv
// Bus sequencer: requests the shared bus and runs one burst after each grant.
// Assumes the grant stays high while the request is held.
// The mode is captured when a burst starts. In multi mode a burst carries all
// four words. In single mode a burst carries one word and the request drops
// in between.
module crw_bus_fsm
    import crw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             have_rec,
    input  logic             bus_gnt,
    input  logic             fifo_full,
    input  logic             single_mode,
    output logic             bus_req,
    output logic             drive,
    output logic [IDX_W-1:0] word_idx,
    output logic             pop
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_WORDS - 1);

    bus_st_e st, st_nx;
    logic    single_q;
    logic    last_beat;

    assign bus_req   = (st != ST_IDLE);
    assign drive     = (st == ST_XFER);
    assign last_beat = drive && (word_idx == LAST_IDX);
    assign pop       = last_beat;

    // Next-state selection for the request and burst sequence.
    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE: if (have_rec)              st_nx = ST_REQ;
            ST_REQ:  if (bus_gnt && !fifo_full) st_nx = ST_XFER;
            ST_XFER: if (single_q || last_beat) st_nx = ST_IDLE;
            default:                            st_nx = ST_IDLE;
        endcase
    end

    // State register, captured mode and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            single_q <= 1'b0;
            word_idx <= '0;
        end else begin
            st <= st_nx;
            if (st == ST_REQ && st_nx == ST_XFER) single_q <= single_mode;
            if (drive) word_idx <= last_beat ? '0 : word_idx + 1'b1;
        end
    end

    // R4 R7: a burst begins only after a grant with room in the FIFO.
    a_r4_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> ($past(bus_gnt) && !$past(fifo_full)));

    // R5: a multi-word burst keeps going until its last word.
    a_r5_multi_run: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && !single_q && word_idx != LAST_IDX) |=> drive);

    // R6: a single-word burst ends after one beat and drops the request.
    a_r6_single_one: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && single_q) |=> (!drive && !bus_req));
endmodule

// File: rtl/conn_rec_writer.sv
// Connectivity record writer, top level.
// Queues a descriptor for each forwarded packet, then writes a four-word record
// into an external FIFO over the memory data bus under its own chip-select.
// Assumes PORTS <= 16, a single-cycle descriptor strobe, and an arbiter that
// grants only in response to bus_req.
module conn_rec_writer
    import crw_pkg::*;
#(
    parameter int PORTS = 8,
    parameter int DEPTH = 4,
    parameter int OVF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    input  logic [PORTS-1:0]  desc_ports,
    input  logic [15:0]       desc_bytes,
    input  logic [47:0]       desc_da,
    input  logic [47:0]       desc_sa,
    input  logic              single_mode,
    input  logic              fifo_full,
    input  logic              bus_gnt,
    output logic              bus_req,
    output logic              bus_oe,
    output logic [31:0]       bus_data,
    output logic              fifo_cs_n,
    output logic [OVF_W-1:0]  ovf_cnt
);
    rec_t              in_rec, head;
    logic              empty, pop, drive;
    logic [IDX_W-1:0]  word_idx;
    logic [WORD_W-1:0] word;

    // Pack the incoming descriptor, widening the mask to its field.
    always_comb begin
        in_rec.ports = MASK_FLD_W'(desc_ports);
        in_rec.bytes = desc_bytes;
        in_rec.da    = desc_da;
        in_rec.sa    = desc_sa;
    end

    crw_queue #(.DEPTH(DEPTH), .OVF_W(OVF_W)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (desc_valid),
        .push_data  (in_rec),
        .pop        (pop),
        .head       (head),
        .empty      (empty),
        .ovf_cnt    (ovf_cnt)
    );

    crw_formatter u_fmt (
        .rec  (head),
        .idx  (word_idx),
        .word (word)
    );

    crw_bus_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .have_rec    (!empty),
        .bus_gnt     (bus_gnt),
        .fifo_full   (fifo_full),
        .single_mode (single_mode),
        .bus_req     (bus_req),
        .drive       (drive),
        .word_idx    (word_idx),
        .pop         (pop)
    );

    // Drive the shared data lines and the chip-select only during a beat.
    always_comb begin
        bus_oe    = drive;
        fifo_cs_n = !drive;
        bus_data  = drive ? word : '0;
    end

    // R3: the data lines stay quiet while the chip-select is high.
    a_r3_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cs_n |-> (bus_data == '0));
endmodule

// File: tb/conn_rec_writer_test.sv
module conn_rec_writer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_valid = 1'b0;
    logic [7:0]  desc_ports = '0;
    logic [15:0] desc_bytes = '0;
    logic [47:0] desc_da = '0, desc_sa = '0;
    logic        single_mode = 1'b0, fifo_full = 1'b0, bus_gnt = 1'b0;
    logic        bus_req, bus_oe, fifo_cs_n;
    logic [31:0] bus_data;
    logic [7:0]  ovf_cnt;

    int checks = 0, bad = 0;
    int gnt_delay = 0;
    logic [31:0] exp_w [1024];
    int exp_recs = 0, exp_words = 0, mon_words = 0, bursts = 0;
    int run = 0;
    logic prev_ok = 1'b0, prev_cs = 1'b1, prev_single = 1'b0, end_pending = 1'b0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conn_rec_writer uut (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ports(desc_ports),
        .desc_bytes(desc_bytes), .desc_da(desc_da), .desc_sa(desc_sa),
        .single_mode(single_mode), .fifo_full(fifo_full), .bus_gnt(bus_gnt),
        .bus_req(bus_req), .bus_oe(bus_oe), .bus_data(bus_data),
        .fifo_cs_n(fifo_cs_n), .ovf_cnt(ovf_cnt)
    );

    task automatic check(input string req, input logic ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // Arbiter model: grants gnt_delay cycles after the request, withdraws after it drops.
    initial begin
        int cnt = 0;
        forever begin
            tick();
            if (!bus_req) begin cnt = 0; bus_gnt = 1'b0; end
            else if (cnt >= gnt_delay) bus_gnt = 1'b1;
            else cnt++;
        end
    end

    // Bus monitor: compares every driven word and checks the shape of each burst.
    always @(negedge clk) begin
        if (rst_n) begin
            if (end_pending) begin
                check("R6 req low after burst", !bus_req, bus_req, 0);
                end_pending = 1'b0;
            end
            if (!fifo_cs_n) begin
                check("R3 oe with cs", bus_oe, bus_oe, 1);
                check("R4 req during burst", bus_req, bus_req, 1);
                if (prev_cs) check("R4 R7 start after grant and not full", prev_ok, prev_ok, 1);
                check("R2 word content", mon_words < exp_words && bus_data == exp_w[mon_words % 1024],
                      bus_data, exp_w[mon_words % 1024]);
                mon_words++;
                run++;
            end else begin
                check("R3 quiet when cs high", !bus_oe && bus_data == 0, bus_data, 0);
                if (run > 0) begin
                    if (prev_single) check("R6 one word per burst", run == 1, run, 1);
                    else             check("R5 four word burst", run == 4, run, 4);
                    bursts++;
                    run = 0;
                    check("R6 req low after burst", !bus_req, bus_req, 0);
                end
            end
            if (fifo_cs_n) prev_single = single_mode;
            prev_ok = bus_gnt && !fifo_full;
            prev_cs = fifo_cs_n;
        end
    end

    function automatic logic [47:0] mk_mac(input int k, input logic [15:0] tag);
        return {tag ^ 16'(k * 16'h1357), 32'(k) * 32'h9E37_79B9 + 32'h0BAD_F00D};
    endfunction

    // Present one descriptor for one cycle; record its expected words if it will be accepted.
    task automatic push(input int k);
        logic [7:0]  p = 8'(k * 37 + 1);
        logic [15:0] b = 16'(64 + k * 29);
        logic [47:0] da = mk_mac(k, 16'hDA5E);
        logic [47:0] sa = mk_mac(k + 7, 16'h5A11);
        if (exp_recs - mon_words / 4 < 4) begin
            exp_w[exp_words % 1024]     = {8'h00, p, b};
            exp_w[(exp_words+1) % 1024] = da[47:16];
            exp_w[(exp_words+2) % 1024] = {da[15:0], sa[47:32]};
            exp_w[(exp_words+3) % 1024] = sa[31:0];
            exp_words += 4;
            exp_recs++;
        end
        desc_valid = 1'b1; desc_ports = p; desc_bytes = b; desc_da = da; desc_sa = sa;
        tick();
        desc_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        int n = 0;
        while ((mon_words < exp_words || !fifo_cs_n) && n < 3000) begin tick(); n++; end
        tick(); tick();
        check(req, mon_words == exp_words, mon_words, exp_words);
    endtask

    task automatic t_reset();
        check("R9 cs_n after reset", fifo_cs_n == 1, fifo_cs_n, 1);
        check("R9 req after reset", bus_req == 0, bus_req, 0);
        check("R9 oe and data after reset", bus_oe == 0 && bus_data == 0, bus_data, 0);
        check("R9 ovf after reset", ovf_cnt == 0, ovf_cnt, 0);
    endtask

    task automatic t_multi_one();
        single_mode = 1'b0; gnt_delay = 2;
        push(1);
        drain("R1 one record multi mode");
        check("R5 one burst for one record", bursts == 1, bursts, 1);
    endtask

    task automatic t_single();
        int b0 = bursts;
        single_mode = 1'b1; gnt_delay = 1;
        push(2); push(3);
        drain("R1 two records single mode");
        check("R6 eight bursts", bursts - b0 == 8, bursts - b0, 8);
        single_mode = 1'b0;
    endtask

    task automatic t_back_to_back();
        int b0 = bursts;
        gnt_delay = 0;
        for (int k = 10; k < 14; k++) push(k);
        drain("R1 four records in order");
        check("R5 four bursts", bursts - b0 == 4, bursts - b0, 4);
        gnt_delay = 5;
        push(20); push(21);
        drain("R4 slow grant records");
    endtask

    task automatic t_full_stall();
        int w0 = mon_words;
        fifo_full = 1'b1; gnt_delay = 0;
        push(30);
        repeat (12) tick();
        check("R7 no write while full", mon_words == w0 && fifo_cs_n, mon_words - w0, 0);
        check("R4 request pending while full", bus_req == 1, bus_req, 1);
        fifo_full = 1'b0;
        drain("R7 record after full clears");
        single_mode = 1'b1;
        fifo_full = 1'b1;
        push(31);
        repeat (8) tick();
        check("R7 single mode waits while full", mon_words == exp_words - 4, mon_words, exp_words - 4);
        fifo_full = 1'b0;
        drain("R7 single mode record after full");
        single_mode = 1'b0;
    endtask

    task automatic t_overflow();
        fifo_full = 1'b1;
        for (int k = 40; k < 45; k++) push(k);
        tick();
        check("R8 one drop at depth four", ovf_cnt == 1, ovf_cnt, 1);
        fifo_full = 1'b0;
        drain("R8 four kept records");
    endtask

    task automatic t_saturate();
        fifo_full = 1'b1;
        for (int k = 50; k < 354; k++) push(k);
        tick();
        check("R10 overflow saturates", ovf_cnt == 8'hFF, ovf_cnt, 8'hFF);
        fifo_full = 1'b0;
        drain("R10 records after saturation");
        check("R10 still saturated", ovf_cnt == 8'hFF, ovf_cnt, 8'hFF);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_multi_one();
        t_single();
        t_back_to_back();
        t_full_stall();
        t_overflow();
        t_saturate();
        check("R1 total words", mon_words == exp_words, mon_words, exp_words);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule